// File: doc/BRIEF.md
# Parallel Share Refresh Gadget

This block takes a value protected by Boolean masking, held as a set of shares packed side by side in one wide word, and re-randomizes it. After refreshing, the XOR of all shares still gives the same secret, but every share carries fresh randomness. All shares are handled in one pass. One or two random vectors, each as wide as the packed word, are XORed into the word together with copies of themselves rotated by whole shares.

Each share is a 16-bit lane, and lane i sits at bits [16i+15:16i]. Rotating by n shares moves the lane with index i to index (i+n) mod d, which equals a left rotation of the packed word by 16·n bits. The share count d is a parameter that can be 4 or 8. With four shares, one random vector is mixed in at distance 1. With eight shares, a second vector is mixed in at distance 2, so 32 random bytes are used instead of the 48 that three chained vectors would need.

Each input transfer carries the masked word and both random words. The result sits in an output register and is offered with a valid/ready handshake.

Top module: `share_refresh`

## Requirements
- R1: For every accepted word, the XOR of all d output lanes equals the XOR of all d input lanes.
- R2: With d = 4, output lane i equals x[i] ^ a[i] ^ a[(i+3) mod 4]. Here x is the input word and a is the first random word, each split into 16-bit lanes with lane 0 at the least significant bits.
- R3: With d = 8, output lane i equals x[i] ^ a[i] ^ a[(i+7) mod 8] ^ b[i] ^ b[(i+6) mod 8]. Here b is the second random word.
- R4: With d = 4, the second random word has no effect on the output word.
- R5: When every random word in use is all zeros, the output word equals the input word.
- R6: A transfer is accepted on a rising edge where in_valid and in_ready are both 1. From the next cycle, out_valid is 1 and out_word holds the result. If out_ready is 1 and no new word is accepted, out_valid returns to 0 on the next edge.
- R7: While out_valid is 1 and out_ready is 0, out_valid and out_word keep their values.
- R8: in_ready is 1 exactly when the output register is empty or is being read in the same cycle (out_valid is 0 or out_ready is 1).
- R9: After an active-low reset, out_valid is 0 and in_ready is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input word and random words are present |
| in_ready | output | 1 | Block can accept an input this cycle |
| in_word | input | 16·NSHARES | Masked word, lane i at bits [16i+15:16i] |
| rnd_a | input | 16·NSHARES | First random vector, rotated by one share |
| rnd_b | input | 16·NSHARES | Second random vector, rotated by two shares; unused when NSHARES = 4 |
| out_valid | output | 1 | Refreshed word is held in the output register |
| out_ready | input | 1 | Consumer takes the output this cycle |
| out_word | output | 16·NSHARES | Refreshed masked word |

## Verification
The bench builds two copies of the block side by side, one with NSHARES = 8 and one with NSHARES = 4, and drives the same handshake into both. Both rotation structures are then exercised under identical stimulus. The four-share copy shows that the second random word is dropped, while the eight-share copy checks the distance-2 term and the lane wrap-around at the top share. A behavioural model computes each lane from the formulas and follows the register occupancy, so the bench can compare the stream under random valid/ready patterns and under stalls that hold the output.

// File: rtl/share_refresh_pkg.sv
package share_refresh_pkg;

    // Width of one share lane in bits
    localparam int unsigned LANE_BITS = 16;

    // Which mixing structure a given share count selects
    typedef enum logic {
        MIX_ONE_VECTOR = 1'b0,
        MIX_TWO_VECTOR = 1'b1
    } mix_kind_e;

    function automatic mix_kind_e mix_kind_for(input int unsigned shares);
        return (shares > 4) ? MIX_TWO_VECTOR : MIX_ONE_VECTOR;
    endfunction

endpackage

// File: rtl/share_rotator.sv
// Rotates a packed word by DIST whole lanes towards higher lane index.
module share_rotator #(
    parameter int unsigned NSHARES = 8,
    parameter int unsigned LANE_W  = 16,
    parameter int unsigned DIST    = 1,
    localparam int unsigned W      = NSHARES * LANE_W
) (
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    for (genvar g = 0; g < NSHARES; g++) begin : g_lane
        localparam int unsigned SRC = (g + NSHARES - (DIST % NSHARES)) % NSHARES;
        assign dout[g*LANE_W +: LANE_W] = din[SRC*LANE_W +: LANE_W];
    end
endmodule

// File: rtl/refresh_mask.sv
// Builds the refresh mask from the random vectors for the chosen share count.
module refresh_mask
    import share_refresh_pkg::*;
#(
    parameter int unsigned NSHARES = 8,
    parameter int unsigned LANE_W  = 16,
    localparam int unsigned W      = NSHARES * LANE_W
) (
    input  logic [W-1:0] rnd_a,
    input  logic [W-1:0] rnd_b,
    output logic [W-1:0] mask
);
    localparam mix_kind_e KIND = mix_kind_for(NSHARES);

    logic [W-1:0] a_rot1;
    logic [W-1:0] b_term;

    share_rotator #(.NSHARES(NSHARES), .LANE_W(LANE_W), .DIST(1)) u_rot_a (
        .din  (rnd_a),
        .dout (a_rot1)
    );

    if (KIND == MIX_TWO_VECTOR) begin : g_two
        logic [W-1:0] b_rot2;
        share_rotator #(.NSHARES(NSHARES), .LANE_W(LANE_W), .DIST(2)) u_rot_b (
            .din  (rnd_b),
            .dout (b_rot2)
        );
        assign b_term = rnd_b ^ b_rot2;
    end else begin : g_one
        // second vector is read but forced out of the mask
        assign b_term = rnd_b & '0;
    end

    assign mask = rnd_a ^ a_rot1 ^ b_term;
endmodule

// File: rtl/share_refresh.sv
module share_refresh
    import share_refresh_pkg::*;
#(
    parameter int unsigned NSHARES = 8,
    parameter int unsigned LANE_W  = LANE_BITS,
    localparam int unsigned W      = NSHARES * LANE_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    output logic         in_ready,
    input  logic [W-1:0] in_word,
    input  logic [W-1:0] rnd_a,
    input  logic [W-1:0] rnd_b,
    output logic         out_valid,
    input  logic         out_ready,
    output logic [W-1:0] out_word
);
    typedef struct packed {
        logic         vld;
        logic [W-1:0] word;
    } state_t;

    state_t       state_d, state_q;
    logic [W-1:0] mask;
    logic         take;

    refresh_mask #(.NSHARES(NSHARES), .LANE_W(LANE_W)) u_mask (
        .rnd_a (rnd_a),
        .rnd_b (rnd_b),
        .mask  (mask)
    );

    assign in_ready  = !state_q.vld || out_ready;
    assign take      = in_valid && in_ready;
    assign out_valid = state_q.vld;
    assign out_word  = state_q.word;

    always_comb begin
        state_d = state_q;
        if (out_ready) begin
            state_d.vld = 1'b0;
        end
        if (take) begin
            state_d.vld  = 1'b1;
            state_d.word = in_word ^ mask;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end
endmodule

// File: rtl/share_refresh_chk.sv
module share_refresh_chk #(
    parameter int unsigned NSHARES = 8,
    parameter int unsigned LANE_W  = 16,
    localparam int unsigned W      = NSHARES * LANE_W
) (
    input logic         clk,
    input logic         rst_n,
    input logic         in_valid,
    input logic         in_ready,
    input logic [W-1:0] in_word,
    input logic [W-1:0] rnd_a,
    input logic [W-1:0] rnd_b,
    input logic         out_valid,
    input logic         out_ready,
    input logic [W-1:0] out_word
);
    function automatic logic [LANE_W-1:0] fold(input logic [W-1:0] w);
        logic [LANE_W-1:0] acc = '0;
        for (int i = 0; i < NSHARES; i++) acc ^= w[i*LANE_W +: LANE_W];
        return acc;
    endfunction

    logic rnd_zero;
    assign rnd_zero = (rnd_a == '0) && ((NSHARES <= 4) || (rnd_b == '0));

    assert_parity_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> (fold(out_word) == $past(fold(in_word))));

    assert_zero_rand_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && rnd_zero) |=> (out_word == $past(in_word)));

    assert_accept_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> out_valid);

    assert_drain_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && !in_valid) |=> !out_valid);

    assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_word)));

    assert_stall_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |-> !in_ready);
endmodule

bind share_refresh share_refresh_chk #(.NSHARES(NSHARES), .LANE_W(LANE_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_word   (in_word),
    .rnd_a     (rnd_a),
    .rnd_b     (rnd_b),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_word  (out_word)
);

// File: tb/test_share_refresh.sv
`timescale 1ns/1ps
module test_share_refresh;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic         out_ready = 1'b0;
    logic [127:0] x = '0, ra = '0, rb = '0;
    logic         rdy8, rdy4, ov8, ov4;
    logic [127:0] ow8;
    logic [63:0]  ow4;

    int checks = 0;
    int fails  = 0;

    // behavioural model state
    bit           mv = 0;
    logic [127:0] m8 = '0;
    logic [63:0]  m4 = '0;
    logic [15:0]  mx8 = '0, mx4 = '0;

    always #10 clk = ~clk;

    share_refresh #(.NSHARES(8)) i_share_refresh (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(rdy8),
        .in_word(x), .rnd_a(ra), .rnd_b(rb),
        .out_valid(ov8), .out_ready(out_ready), .out_word(ow8)
    );

    share_refresh #(.NSHARES(4)) i_share_refresh_s4 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(rdy4),
        .in_word(x[63:0]), .rnd_a(ra[63:0]), .rnd_b(rb[63:0]),
        .out_valid(ov4), .out_ready(out_ready), .out_word(ow4)
    );

    function automatic logic [15:0] ln(input logic [127:0] w, input int i);
        return w[i*16 +: 16];
    endfunction

    function automatic logic [127:0] ref8(input logic [127:0] xw, a, b);
        logic [127:0] r = '0;
        for (int i = 0; i < 8; i++)
            r[i*16 +: 16] = ln(xw,i) ^ ln(a,i) ^ ln(a,(i+7)%8) ^ ln(b,i) ^ ln(b,(i+6)%8);
        return r;
    endfunction

    function automatic logic [63:0] ref4(input logic [127:0] xw, a);
        logic [63:0] r = '0;
        for (int i = 0; i < 4; i++)
            r[i*16 +: 16] = ln(xw,i) ^ ln(a,i) ^ ln(a,(i+3)%4);
        return r;
    endfunction

    function automatic logic [15:0] fold(input logic [127:0] w, input int n);
        logic [15:0] acc = '0;
        for (int i = 0; i < n; i++) acc ^= ln(w,i);
        return acc;
    endfunction

    function automatic logic [127:0] rnd128();
        return {$urandom, $urandom, $urandom, $urandom};
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [127:0] act, exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // one cycle: drive at negedge, predict, check after the next edge
    task automatic step(input bit iv, input bit ordy,
                        input logic [127:0] xw, a, b);
        bit exp_rdy;
        in_valid = iv; out_ready = ordy; x = xw; ra = a; rb = b;
        #1;
        exp_rdy = !mv || ordy;
        chk(rdy8 == exp_rdy, "R8 ready 8-share", 128'(rdy8), 128'(exp_rdy));
        chk(rdy4 == exp_rdy, "R8 ready 4-share", 128'(rdy4), 128'(exp_rdy));
        if (ordy) mv = 0;
        if (iv && exp_rdy) begin
            mv  = 1;
            m8  = ref8(xw, a, b);
            m4  = ref4(xw, a);
            mx8 = fold(xw, 8);
            mx4 = fold(xw, 4);
        end
        @(posedge clk);
        @(negedge clk);
        chk(ov8 == mv, "R6/R7 valid 8-share", 128'(ov8), 128'(mv));
        chk(ov4 == mv, "R6/R7 valid 4-share", 128'(ov4), 128'(mv));
        if (mv) begin
            chk(ow8 == m8, "R3 word 8-share", ow8, m8);
            chk(ow4 == m4, "R2 word 4-share", 128'(ow4), 128'(m4));
            chk(fold(ow8, 8) == mx8, "R1 parity 8-share", 128'(fold(ow8, 8)), 128'(mx8));
            chk(fold(128'(ow4), 4) == mx4, "R1 parity 4-share", 128'(fold(128'(ow4), 4)), 128'(mx4));
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL R6 watchdog expired actual=hung expected=finished");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        logic [127:0] v, held8;
        logic [63:0]  held4;
        repeat (3) @(negedge clk);
        // R9: state during and after reset
        #1;
        chk(ov8 == 1'b0 && ov4 == 1'b0, "R9 valid in reset", 128'({ov8, ov4}), 128'(0));
        rst_n = 1'b1;
        @(negedge clk);
        chk(ov8 == 1'b0 && ov4 == 1'b0, "R9 valid after reset", 128'({ov8, ov4}), 128'(0));
        chk(rdy8 && rdy4, "R9 ready after reset", 128'({rdy8, rdy4}), 128'(3));

        // R2 R3 R1: streaming random words
        for (int k = 0; k < 30; k++) step(1, 1, rnd128(), rnd128(), rnd128());

        // R5: zero randomness leaves the word untouched
        v = rnd128();
        step(1, 1, v, '0, '0);
        chk(ow8 == v, "R5 zero random 8-share", ow8, v);
        chk(ow4 == v[63:0], "R5 zero random 4-share", 128'(ow4), 128'(v[63:0]));

        // R4: second vector must not reach the 4-share output
        v = rnd128();
        step(1, 1, v, '0, rnd128());
        chk(ow4 == v[63:0], "R4 rnd_b ignored 4-share", 128'(ow4), 128'(v[63:0]));

        // R7: stall holds the output
        step(1, 0, rnd128(), rnd128(), rnd128());
        held8 = ow8; held4 = ow4;
        for (int k = 0; k < 4; k++) begin
            step(1, 0, rnd128(), rnd128(), rnd128());
            chk(ow8 == held8, "R7 hold 8-share", ow8, held8);
            chk(ow4 == held4, "R7 hold 4-share", 128'(ow4), 128'(held4));
        end
        step(0, 1, '0, '0, '0);   // drain: R6 valid drops
        step(0, 1, rnd128(), rnd128(), rnd128());

        // random handshake mix
        for (int k = 0; k < 300; k++)
            step(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                 rnd128(), rnd128(), rnd128());
        step(0, 1, '0, '0, '0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule